// File: doc/BRIEF.md
# Dual Calendar Alarm Interrupt Controller

This block watches the running weekday, hour and minute of a real-time clock and raises an alarm when they agree with a programmed setting. It holds two independent alarm channels. Each channel has its own minute, hour and weekday-mask setting and its own enable and flag bit. When a channel's setting agrees with the calendar, its flag is set and stays set until software writes it to zero. A shared active-low interrupt pin is pulled low while any enabled channel has its flag set.

The calendar values come in as inputs, together with a one-cycle pulse that marks each new minute. The block compares the calendar only on that pulse, so each one-minute agreement is a single event. Software reaches the settings, the enables and the flags through a small address/data/write-strobe port with a combinational read path. Both flags and both enables share one status word, so software can poll the alarms without watching the pin.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset every alarm field, enable and flag is zero, the read port returns zero at every address, and `irqN` is high.
- R2: Writes to addresses 0x0/0x1/0x2 load channel A's minute, hour and weekday mask (mask in bits 6:0, bit n for weekday n), and writes to 0x3/0x4/0x5 do the same for channel B. Each of these reads back what was written, with mask bit 7 reading 0. Addresses 0x6 to 0xE read 0.
- R3: A channel matches when the mask bit of `curWeekday` is set (weekday 7 never matches) and hour and minute are equal byte for byte. An enabled channel whose match rises on a `minTick` cycle reads its flag as 1 from the next cycle.
- R4: The flag is set only when the match sampled on the previous `minTick` was false. Further ticks inside the same agreement do not set it again.
- R5: A set flag stays set while its channel is enabled, until software writes it to zero.
- R6: A write to status address 0xF loads enable A from bit 7 and enable B from bit 6. It clears flag A if bit 1 is 0 and flag B if bit 0 is 0. A 1 in a flag bit leaves that flag unchanged. Reads of 0xF return these bits in the same positions, with all other bits 0.
- R7: `irqN` is low exactly when at least one enabled channel has its flag set, and it returns high once both flags are cleared.
- R8: While a channel is disabled its flag reads 0 and cannot pull `irqN` low. Disabling a channel clears its flag, so enabling it again raises no stale interrupt.
- R9: If a flag set and a software clear of the same flag fall in the same cycle, the set wins.
- R10: A flag that software clears during an ongoing agreement is not set again until the match has gone false on a tick and then risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address, used for both read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| minTick | input | 1 | One-cycle pulse at each new minute |
| curWeekday | input | 3 | Current weekday, 0 to 6 |
| curHour | input | 8 | Current hour, BCD |
| curMinute | input | 8 | Current minute, BCD |
| irqN | output | 1 | Shared active-low alarm interrupt |

## Verification
The assertions assume that `minTick` is a single-cycle pulse and that the calendar inputs change only in the cycles around a tick. A rising match therefore cannot repeat on back-to-back ticks. The stimulus raises `minTick` for exactly one cycle, always with idle cycles around it, and changes weekday, hour and minute only while the tick is low. Register writes last one cycle each. The single exception is the collision case for R9, where a status write is made to coincide with a tick on purpose.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_CH   = 2;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int DAYS     = 7;
  localparam int WDAY_W   = 3;
  localparam int FIELDS   = 3;  // minute, hour, weekday mask per channel
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(15);

  typedef struct packed {
    logic [NUM_CH-1:0] setFlag;
    logic [NUM_CH-1:0] clrFlag;
    logic [NUM_CH-1:0] wrMin;
    logic [NUM_CH-1:0] wrHour;
    logic [NUM_CH-1:0] wrDay;
    logic              wrStat;
  } strobe_t;
endpackage

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              minTick,
  input  logic [NUM_CH-1:0] match,
  output strobe_t           strb
);
  logic [NUM_CH-1:0] prevMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMatch <= '0;
    else if (minTick) prevMatch <= match;
  end

  always_comb begin
    strb = '0;
    strb.wrStat = wrEn && (addr == STAT_ADDR);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strb.wrMin[ch]   = wrEn && (addr == ADDR_W'(ch*FIELDS));
      strb.wrHour[ch]  = wrEn && (addr == ADDR_W'(ch*FIELDS + 1));
      strb.wrDay[ch]   = wrEn && (addr == ADDR_W'(ch*FIELDS + 2));
      strb.clrFlag[ch] = strb.wrStat && !wrData[NUM_CH-1-ch];
      strb.setFlag[ch] = minTick && match[ch] && !prevMatch[ch];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R4
    single_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.setFlag[g] |=> !strb.setFlag[g]);
  end
endmodule

// File: rtl/alarm_irq_dp.sv
module alarm_irq_dp
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [WDAY_W-1:0] curWeekday,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curMinute,
  output logic [NUM_CH-1:0] match,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);
  logic [DATA_W-1:0] minReg  [NUM_CH];
  logic [DATA_W-1:0] hourReg [NUM_CH];
  logic [DAYS-1:0]   dayReg  [NUM_CH];
  logic [NUM_CH-1:0] enQ;
  logic [NUM_CH-1:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        minReg[ch]  <= '0;
        hourReg[ch] <= '0;
        dayReg[ch]  <= '0;
      end
      enQ   <= '0;
      flagQ <= '0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (strb.wrMin[ch])  minReg[ch]  <= wrData;
        if (strb.wrHour[ch]) hourReg[ch] <= wrData;
        if (strb.wrDay[ch])  dayReg[ch]  <= wrData[DAYS-1:0];
        if (strb.wrStat)     enQ[ch]     <= wrData[DATA_W-1-ch];
        if (!enQ[ch])                flagQ[ch] <= 1'b0;
        else if (strb.setFlag[ch])   flagQ[ch] <= 1'b1;
        else if (strb.clrFlag[ch])   flagQ[ch] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gMatch
    logic dayHit;
    assign dayHit   = |(dayReg[g] & (DAYS'(1) << curWeekday));
    assign match[g] = dayHit && (hourReg[g] == curHour) && (minReg[g] == curMinute);
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == ADDR_W'(ch*FIELDS))     rdData = minReg[ch];
      if (addr == ADDR_W'(ch*FIELDS + 1)) rdData = hourReg[ch];
      if (addr == ADDR_W'(ch*FIELDS + 2)) rdData = DATA_W'(dayReg[ch]);
    end
    if (addr == STAT_ADDR) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        rdData[DATA_W-1-ch] = enQ[ch];
        rdData[NUM_CH-1-ch] = flagQ[ch] & enQ[ch];
      end
    end
  end

  assign irqN = ~|(flagQ & enQ);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R3
    rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.setFlag[g] |=> !$rose(flagQ[g]));
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      flagQ[g] && enQ[g] && !strb.clrFlag[g] |=> flagQ[g]);
    // R8
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      !enQ[g] |=> !flagQ[g]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.setFlag[g] && enQ[g] |=> flagQ[g]);
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              minTick,
  input  logic [WDAY_W-1:0] curWeekday,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curMinute,
  output logic              irqN
);
  strobe_t           strb;
  logic [NUM_CH-1:0] match;

  alarm_irq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .minTick(minTick), .match(match), .strb(strb)
  );

  alarm_irq_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .curWeekday(curWeekday), .curHour(curHour), .curMinute(curMinute),
    .match(match), .rdData(rdData), .irqN(irqN)
  );
endmodule

// File: tb/test_rtc_alarm_irq.sv
`timescale 1ns/100ps
module test_rtc_alarm_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = 4'hF;
  logic [7:0] wrData = '0;
  logic minTick = 1'b0;
  logic [2:0] curWeekday = '0;
  logic [7:0] curHour = '0;
  logic [7:0] curMinute = '0;
  logic [7:0] rdData;
  logic irqN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [7:0] mMin [2];
  logic [7:0] mHour [2];
  logic [7:0] mDay [2];
  bit mEn [2];
  bit mFlag [2];
  bit mPrev [2];

  always #2.5 clk = ~clk;

  rtc_alarm_irq i_rtc_alarm_irq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .minTick(minTick), .curWeekday(curWeekday),
    .curHour(curHour), .curMinute(curMinute), .irqN(irqN)
  );

  function automatic bit agrees(int c);
    if (curWeekday > 3'd6) return 0;
    return mDay[c][curWeekday] && mHour[c] == curHour && mMin[c] == curMinute;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      foreach (mEn[c]) begin
        mMin[c] = 0; mHour[c] = 0; mDay[c] = 0;
        mEn[c] = 0; mFlag[c] = 0; mPrev[c] = 0;
      end
    end else begin
      bit hit [2];
      bit oldEn [2];
      foreach (mEn[c]) begin
        hit[c] = agrees(c);
        oldEn[c] = mEn[c];
      end
      foreach (mEn[c]) begin
        if (!oldEn[c]) mFlag[c] = 0;
        else if (minTick && hit[c] && !mPrev[c]) mFlag[c] = 1;
        else if (wrEn && addr == 4'hF && wrData[1-c] == 1'b0) mFlag[c] = 0;
        if (minTick) mPrev[c] = hit[c];
        if (wrEn && addr == 4'(3*c))     mMin[c] = wrData;
        if (wrEn && addr == 4'(3*c + 1)) mHour[c] = wrData;
        if (wrEn && addr == 4'(3*c + 2)) mDay[c] = {1'b0, wrData[6:0]};
        if (wrEn && addr == 4'hF)        mEn[c] = wrData[7-c];
      end
    end
  end

  function automatic logic [7:0] expRead();
    logic [7:0] v = '0;
    for (int c = 0; c < 2; c++) begin
      if (addr == 4'(3*c))     v = mMin[c];
      if (addr == 4'(3*c + 1)) v = mHour[c];
      if (addr == 4'(3*c + 2)) v = mDay[c];
    end
    if (addr == 4'hF) begin
      v[7] = mEn[0]; v[6] = mEn[1];
      v[1] = mFlag[0] & mEn[0]; v[0] = mFlag[1] & mEn[1];
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (cycles > 0) begin
      logic expIrq;
      expIrq = !((mFlag[0] && mEn[0]) || (mFlag[1] && mEn[1]));
      checks++;
      if (irqN !== expIrq) begin
        errors++;
        $display("FAIL %s irqN: actual %b expected %b at cycle %0d", curReq, irqN, expIrq, cycles);
      end
      checks++;
      if (rdData !== expRead()) begin
        errors++;
        $display("FAIL %s rdData@%h: actual %h expected %h at cycle %0d", curReq, addr, rdData, expRead(), cycles);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wrEn = 1; addr = a; wrData = d;
    step();
    wrEn = 0; addr = 4'hF;
    step();
  endtask

  task automatic rd(logic [3:0] a);
    addr = a;
    step();
  endtask

  task automatic setTime(logic [2:0] wd, logic [7:0] h, logic [7:0] m);
    curWeekday = wd; curHour = h; curMinute = m;
    step();
    minTick = 1;
    step();
    minTick = 0;
    step(2);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    step(3);
    for (int a = 0; a < 16; a++) rd(4'(a));
    rstN = 1;
    step();
    for (int a = 0; a < 16; a++) rd(4'(a));

    // R2: field write and readback
    curReq = "R2";
    wr(4'h0, 8'h30); wr(4'h1, 8'h12); wr(4'h2, 8'h84);
    wr(4'h3, 8'h45); wr(4'h4, 8'h08); wr(4'h5, 8'h7F);
    for (int a = 0; a < 16; a++) rd(4'(a));

    // R6: enable A only, 1 in flag bits does nothing
    curReq = "R6";
    wr(4'hF, 8'h83);

    // R3: match on weekday 2, 12:30
    curReq = "R3";
    setTime(3'd2, 8'h12, 8'h30);
    // R7: interrupt low while flag set
    curReq = "R7";
    step(3);
    // R6: writing 1 leaves flag set
    curReq = "R6";
    wr(4'hF, 8'h83);
    // R5: stays set across non-matching ticks
    curReq = "R5";
    setTime(3'd2, 8'h12, 8'h31);
    setTime(3'd3, 8'h12, 8'h30);
    // R10: clear inside an ongoing agreement, then tick again
    curReq = "R10";
    setTime(3'd2, 8'h12, 8'h30);
    wr(4'hF, 8'h81);
    setTime(3'd2, 8'h12, 8'h30);
    // R4: fall then rise sets again
    curReq = "R4";
    setTime(3'd2, 8'h12, 8'h31);
    setTime(3'd2, 8'h12, 8'h30);
    setTime(3'd2, 8'h12, 8'h30);
    // R3: weekday outside mask and weekday 7 do not match
    curReq = "R3";
    wr(4'hF, 8'h81);
    setTime(3'd3, 8'h12, 8'h31);
    setTime(3'd3, 8'h12, 8'h30);
    setTime(3'd7, 8'h12, 8'h30);

    // R8: disabling clears, no set while disabled, no stale on re-enable
    curReq = "R8";
    setTime(3'd2, 8'h12, 8'h30);
    wr(4'hF, 8'h03);
    setTime(3'd2, 8'h12, 8'h31);
    setTime(3'd2, 8'h12, 8'h30);
    wr(4'hF, 8'h83);
    step(2);

    // R7: channel B, clearing B alone releases the pin
    curReq = "R7";
    wr(4'hF, 8'hC3);
    setTime(3'd5, 8'h08, 8'h45);
    wr(4'hF, 8'hC2);
    step(2);

    // R9: set and clear in the same cycle
    curReq = "R9";
    setTime(3'd5, 8'h08, 8'h46);
    curWeekday = 3'd5; curHour = 8'h08; curMinute = 8'h45;
    step();
    minTick = 1; wrEn = 1; addr = 4'hF; wrData = 8'hC2;
    step();
    minTick = 0; wrEn = 0;
    step(3);

    // R7: both set, clear one then the other
    curReq = "R7";
    wr(4'h4, 8'h12); wr(4'h3, 8'h30); wr(4'h5, 8'h04);
    wr(4'hF, 8'hC0);
    setTime(3'd2, 8'h12, 8'h31);
    setTime(3'd2, 8'h12, 8'h30);
    wr(4'hF, 8'hC1);
    wr(4'hF, 8'hC0);
    step(2);

    finish();
  end
endmodule